// File: doc/BRIEF.md
# Single-Precision Compare, Min/Max, Sign and Classify Unit

This block carries out the light single-precision floating-point operations that need no adder or multiplier. It orders two operands with less-than, less-or-equal and equality tests. It picks the smaller or larger of two operands. It flips or clears the sign bit to negate or take an absolute value. It sorts an operand into one of ten IEEE-754 classes. Each operation is issued with a one-cycle valid strobe, and its result comes out after a latency fixed by its class. No handshake exists: an issue is accepted in the cycle its strobe is high.

The operations do not all treat subnormal inputs the same way. The ordering tests flush subnormals to zero before comparing. Min/max, the sign operations and classification work on the exact bit pattern. The invalid flag is reported with the result of the same operation. Gathering flags across operations is left to the surrounding pipeline.

Top module: `fpmisc_unit`

## Requirements
- R1: The opcode `op_i` is 3 bits wide: 0 less-than, 1 less-or-equal, 2 equal, 3 minimum, 4 maximum, 5 negate, 6 absolute value, 7 classify. The three comparisons raise `res_valid_o` one clock edge after the issue edge. The result holds 1 (true) or 0 (false) in bit 0, and all other bits are zero.
- R2: Comparisons treat any operand with a zero exponent field as zero, whatever its sign and mantissa. So +0 equals −0, any two subnormals compare equal, and a subnormal equals zero.
- R3: With a NaN operand, less-than and less-or-equal return 0 and raise `invalid_o`. Equal returns 0 and raises `invalid_o` only if an operand is a signalling NaN (all-ones exponent, nonzero mantissa, mantissa bit 22 clear).
- R4: Minimum returns a when a<b and b otherwise. Maximum returns b when a<b and a otherwise. Both compare exact values, subnormals included, with −0 ordered below +0. The result appears two clock edges after the issue edge.
- R5: When exactly one operand of minimum or maximum is NaN, the other operand is returned. When both are NaN, the canonical NaN 0x7FC00000 is returned. `invalid_o` is raised when either operand is a signalling NaN.
- R6: Negate inverts bit 31 and absolute value clears bit 31. Bits 30..0 pass through unchanged, subnormal and NaN patterns included. The result appears one clock edge after the issue edge.
- R7: Classify returns, two clock edges after issue, a one-hot mask in bits 9..0 with the upper bits zero. Bit 0 −inf, 1 −normal, 2 −subnormal, 3 −0, 4 +0, 5 +subnormal, 6 +normal, 7 +inf, 8 signalling NaN, 9 quiet NaN.
- R8: `res_valid_o` is high for exactly one cycle per delivered result and never without a matching issue. `invalid_o` is 0 for negate, absolute value and classify.
- R9: If a two-cycle operation is issued and a one-cycle operation follows in the very next cycle, both would finish in the same cycle. The two-cycle result is then delivered and the one-cycle result is discarded.
- R10: While `rst` is high and in the cycle after, `res_valid_o`, `result_o` and `invalid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Operation issue strobe |
| op_i | input | 3 | Operation code |
| opa_i | input | 32 | Operand a |
| opb_i | input | 32 | Operand b (ignored by negate, absolute value, classify) |
| res_valid_o | output | 1 | Result strobe |
| result_o | output | 32 | Result word |
| invalid_o | output | 1 | Invalid-operation flag for this result |

## Verification
The hardest case to reach from the ports is the output collision. A two-cycle operation and a one-cycle operation must be issued on back-to-back cycles in that order, so that both complete on the same edge. The driver issues a minimum and then a negate with no idle cycle between them. The scoreboard leaves out the negate's expected item and checks that the minimum's result is the only one delivered. Subnormal pairs with different mantissas and signs are also issued to both the comparison and the min/max operations. This separates the flushing path from the exact path.

// File: rtl/fpmisc_pkg.sv
package fpmisc_pkg;

    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int FP_W    = 1 + EXP_W + MAN_W;
    localparam int CLASS_W = 10;
    localparam int OP_W    = 3;

    typedef logic [FP_W-1:0] fp_t;

    typedef enum logic [OP_W-1:0] {
        OP_LT    = 3'd0,
        OP_LE    = 3'd1,
        OP_EQ    = 3'd2,
        OP_MIN   = 3'd3,
        OP_MAX   = 3'd4,
        OP_NEG   = 3'd5,
        OP_ABS   = 3'd6,
        OP_CLASS = 3'd7
    } fp_op_e;

    typedef struct packed {
        logic valid;
        fp_t  value;
        logic inv;
    } fp_res_t;

    localparam fp_t CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    function automatic logic exp_all_ones(fp_t x);
        return &x[FP_W-2:MAN_W];
    endfunction

    function automatic logic exp_all_zero(fp_t x);
        return ~|x[FP_W-2:MAN_W];
    endfunction

    function automatic logic is_nan(fp_t x);
        return exp_all_ones(x) && (|x[MAN_W-1:0]);
    endfunction

    function automatic logic is_snan(fp_t x);
        return is_nan(x) && !x[MAN_W-1];
    endfunction

    // Map a float onto an unsigned key whose integer order follows numeric
    // order. With flush set, every zero-exponent pattern collapses to +0.
    function automatic fp_t order_key(fp_t x, logic flush);
        fp_t v;
        v = (flush && exp_all_zero(x)) ? '0 : x;
        if (v[FP_W-1])
            return ~v;
        return {1'b1, v[FP_W-2:0]};
    endfunction

endpackage

// File: rtl/fpmisc_cmp.sv
module fpmisc_cmp
    import fpmisc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take_i,
    input  fp_op_e op_i,
    input  fp_t    a_i,
    input  fp_t    b_i,
    output fp_res_t out_o
);

    fp_t  key_a, key_b;
    logic any_nan, any_snan, less, same, truth, raise;

    always_comb begin
        key_a    = order_key(a_i, 1'b1);
        key_b    = order_key(b_i, 1'b1);
        any_nan  = is_nan(a_i) || is_nan(b_i);
        any_snan = is_snan(a_i) || is_snan(b_i);
        less     = key_a < key_b;
        same     = key_a == key_b;
        truth    = 1'b0;
        raise    = 1'b0;
        unique case (op_i)
            OP_LT: begin truth = !any_nan && less;           raise = any_nan;  end
            OP_LE: begin truth = !any_nan && (less || same); raise = any_nan;  end
            OP_EQ: begin truth = !any_nan && same;           raise = any_snan; end
            default: begin truth = 1'b0; raise = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= '0;
        end else begin
            out_o.valid <= take_i;
            out_o.value <= take_i ? {{(FP_W-1){1'b0}}, truth} : '0;
            out_o.inv   <= take_i && raise;
        end
    end

    // R1: a comparison result is a single boolean bit
    a_r1_cmp_boolean: assert property (@(posedge clk) disable iff (rst)
        out_o.valid |-> out_o.value[FP_W-1:1] == '0);

    // R3: an ordering test involving a NaN is never true
    a_r3_nan_false: assert property (@(posedge clk) disable iff (rst)
        (out_o.valid && $past(is_nan(a_i) || is_nan(b_i))) |-> out_o.value == '0);

endmodule

// File: rtl/fpmisc_minmax.sv
module fpmisc_minmax
    import fpmisc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    take_i,
    input  logic    want_max_i,
    input  fp_t     a_i,
    input  fp_t     b_i,
    output fp_res_t out_o
);

    logic s1_valid, s1_max;
    fp_t  s1_a, s1_b;
    fp_t  pick;
    logic pick_inv, a_below;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_max   <= 1'b0;
            s1_a     <= '0;
            s1_b     <= '0;
        end else begin
            s1_valid <= take_i;
            if (take_i) begin
                s1_max <= want_max_i;
                s1_a   <= a_i;
                s1_b   <= b_i;
            end
        end
    end

    always_comb begin
        a_below  = order_key(s1_a, 1'b0) < order_key(s1_b, 1'b0);
        pick_inv = is_snan(s1_a) || is_snan(s1_b);
        if (is_nan(s1_a) && is_nan(s1_b))
            pick = CANON_NAN;
        else if (is_nan(s1_a))
            pick = s1_b;
        else if (is_nan(s1_b))
            pick = s1_a;
        else if (s1_max)
            pick = a_below ? s1_b : s1_a;
        else
            pick = a_below ? s1_a : s1_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= '0;
        end else begin
            out_o.valid <= s1_valid;
            out_o.value <= s1_valid ? pick : '0;
            out_o.inv   <= s1_valid && pick_inv;
        end
    end

    // R4: the chosen value is always one of the operands or the canonical NaN
    a_r4_pick_operand: assert property (@(posedge clk) disable iff (rst)
        out_o.valid |-> (out_o.value == $past(s1_a) || out_o.value == $past(s1_b)
                         || out_o.value == CANON_NAN));

    // R5: a NaN is returned only when both operands were NaN
    a_r5_nan_only_both: assert property (@(posedge clk) disable iff (rst)
        (out_o.valid && is_nan(out_o.value)) |-> ($past(is_nan(s1_a)) && $past(is_nan(s1_b))));

endmodule

// File: rtl/fpmisc_sign.sv
module fpmisc_sign
    import fpmisc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    take_i,
    input  logic    clear_i,
    input  fp_t     a_i,
    output fp_res_t out_o
);

    logic new_sign;

    always_comb new_sign = clear_i ? 1'b0 : !a_i[FP_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= '0;
        end else begin
            out_o.valid <= take_i;
            out_o.value <= take_i ? {new_sign, a_i[FP_W-2:0]} : '0;
            out_o.inv   <= 1'b0;
        end
    end

    // R6: only the sign bit may differ from the operand
    a_r6_magnitude_kept: assert property (@(posedge clk) disable iff (rst)
        out_o.valid |-> out_o.value[FP_W-2:0] == $past(a_i[FP_W-2:0]));

endmodule

// File: rtl/fpmisc_class.sv
module fpmisc_class
    import fpmisc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    take_i,
    input  fp_t     a_i,
    output fp_res_t out_o
);

    logic s1_valid;
    fp_t  s1_a;
    logic [CLASS_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_a     <= '0;
        end else begin
            s1_valid <= take_i;
            if (take_i)
                s1_a <= a_i;
        end
    end

    always_comb begin
        logic neg, man_zero;
        neg      = s1_a[FP_W-1];
        man_zero = ~|s1_a[MAN_W-1:0];
        mask     = '0;
        if (is_nan(s1_a))
            mask[s1_a[MAN_W-1] ? 9 : 8] = 1'b1;
        else if (exp_all_ones(s1_a))
            mask[neg ? 0 : 7] = 1'b1;
        else if (exp_all_zero(s1_a) && man_zero)
            mask[neg ? 3 : 4] = 1'b1;
        else if (exp_all_zero(s1_a))
            mask[neg ? 2 : 5] = 1'b1;
        else
            mask[neg ? 1 : 6] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= '0;
        end else begin
            out_o.valid <= s1_valid;
            out_o.value <= s1_valid ? {{(FP_W-CLASS_W){1'b0}}, mask} : '0;
            out_o.inv   <= 1'b0;
        end
    end

    // R7: exactly one class bit is set, nothing above the mask
    a_r7_class_onehot: assert property (@(posedge clk) disable iff (rst)
        out_o.valid |-> ($countones(out_o.value[CLASS_W-1:0]) == 1
                         && out_o.value[FP_W-1:CLASS_W] == '0));

endmodule

// File: rtl/fpmisc_unit.sv
module fpmisc_unit
    import fpmisc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_i,
    input  logic [OP_W-1:0]      op_i,
    input  logic [FP_W-1:0]      opa_i,
    input  logic [FP_W-1:0]      opb_i,
    output logic                 res_valid_o,
    output logic [FP_W-1:0]      result_o,
    output logic                 invalid_o
);

    fp_op_e  op;
    logic    go_cmp, go_mm, go_sgn, go_cls;
    fp_res_t r_cmp, r_mm, r_sgn, r_cls, sel;

    always_comb begin
        op     = fp_op_e'(op_i);
        go_cmp = issue_i && (op == OP_LT || op == OP_LE || op == OP_EQ);
        go_mm  = issue_i && (op == OP_MIN || op == OP_MAX);
        go_sgn = issue_i && (op == OP_NEG || op == OP_ABS);
        go_cls = issue_i && (op == OP_CLASS);
    end

    fpmisc_cmp u_cmp (
        .clk(clk), .rst(rst), .take_i(go_cmp), .op_i(op),
        .a_i(opa_i), .b_i(opb_i), .out_o(r_cmp)
    );

    fpmisc_minmax u_mm (
        .clk(clk), .rst(rst), .take_i(go_mm), .want_max_i(op == OP_MAX),
        .a_i(opa_i), .b_i(opb_i), .out_o(r_mm)
    );

    fpmisc_sign u_sgn (
        .clk(clk), .rst(rst), .take_i(go_sgn), .clear_i(op == OP_ABS),
        .a_i(opa_i), .out_o(r_sgn)
    );

    fpmisc_class u_cls (
        .clk(clk), .rst(rst), .take_i(go_cls),
        .a_i(opa_i), .out_o(r_cls)
    );

    // Two-cycle paths take precedence: their issue is the older one.
    always_comb begin
        if (r_mm.valid)       sel = r_mm;
        else if (r_cls.valid) sel = r_cls;
        else if (r_cmp.valid) sel = r_cmp;
        else if (r_sgn.valid) sel = r_sgn;
        else                  sel = '0;
    end

    assign res_valid_o = sel.valid;
    assign result_o    = sel.value;
    assign invalid_o   = sel.inv;

    // R8: no result without an issue one or two cycles earlier
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> ($past(issue_i) || $past(issue_i, 2)));

    // R9: on a collision the older, two-cycle result reaches the port
    a_r9_older_wins: assert property (@(posedge clk) disable iff (rst)
        ($past(go_mm, 2) && $past(go_sgn)) |-> (res_valid_o && result_o == r_mm.value));

endmodule

// File: tb/sim_fpmisc_unit.sv
module sim_fpmisc_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] a = '0, b = '0;
    logic        rv;
    logic [31:0] res;
    logic        inv;

    fpmisc_unit u0 (
        .clk(clk), .rst(rst), .issue_i(issue), .op_i(op), .opa_i(a), .opb_i(b),
        .res_valid_o(rv), .result_o(res), .invalid_o(inv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          due;
        logic [31:0] value;
        logic        flag;
        string       tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit running = 0;

    localparam logic [31:0] P1 = 32'h3F80_0000, N1 = 32'hBF80_0000, P2 = 32'h4000_0000;
    localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
    localparam logic [31:0] PSUB = 32'h0000_0001, PSUB2 = 32'h0040_0000, NSUB = 32'h8000_0010;
    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
    localparam logic [31:0] QNAN = 32'h7FC0_0000, QNAN2 = 32'h7FC1_2345, SNAN = 32'h7F80_0001;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit nan_of(logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 0;
    endfunction

    function automatic bit snan_of(logic [31:0] x);
        return nan_of(x) && x[22] == 1'b0;
    endfunction

    // numeric ordering from sign and magnitude; flush maps zero exponents to 0
    function automatic bit below(logic [31:0] x, logic [31:0] y, bit flush);
        logic [30:0] mx, my;
        bit sx, sy;
        mx = (flush && x[30:23] == 0) ? '0 : x[30:0];
        my = (flush && y[30:23] == 0) ? '0 : y[30:0];
        sx = (flush && mx == 0) ? 1'b0 : x[31];
        sy = (flush && my == 0) ? 1'b0 : y[31];
        if (sx != sy) return sx;
        if (!sx) return mx < my;
        return mx > my;
    endfunction

    function automatic bit alike(logic [31:0] x, logic [31:0] y);
        return !below(x, y, 1) && !below(y, x, 1);
    endfunction

    function automatic logic [31:0] class_of(logic [31:0] x);
        int k;
        if (nan_of(x))                         k = x[22] ? 9 : 8;
        else if (x[30:0] == 31'h7F80_0000)     k = x[31] ? 0 : 7;
        else if (x[30:0] == 0)                 k = x[31] ? 3 : 4;
        else if (x[30:23] == 0)                k = x[31] ? 2 : 5;
        else                                   k = x[31] ? 1 : 6;
        return 32'd1 << k;
    endfunction

    function automatic logic [32:0] model(logic [2:0] o, logic [31:0] x, logic [31:0] y);
        bit n = nan_of(x) || nan_of(y);
        bit s = snan_of(x) || snan_of(y);
        case (o)
            3'd0: return {32'(!n && below(x, y, 1)), n};
            3'd1: return {32'(!n && !below(y, x, 1)), n};
            3'd2: return {32'(!n && alike(x, y)), s};
            3'd3, 3'd4: begin
                logic [31:0] r;
                if (nan_of(x) && nan_of(y)) r = 32'h7FC0_0000;
                else if (nan_of(x)) r = y;
                else if (nan_of(y)) r = x;
                else if (o == 3'd3) r = below(x, y, 0) ? x : y;
                else r = below(x, y, 0) ? y : x;
                return {r, s};
            end
            3'd5: return {~x[31], x[30:0], 1'b0};
            3'd6: return {1'b0, x[30:0], 1'b0};
            default: return {class_of(x), 1'b0};
        endcase
    endfunction

    task automatic issue_op(logic [2:0] o, logic [31:0] x, logic [31:0] y, string tag);
        item_t it;
        logic [32:0] m;
        @(negedge clk);
        issue = 1'b1; op = o; a = x; b = y;
        m = model(o, x, y);
        it.due = cyc + ((o == 3'd3 || o == 3'd4 || o == 3'd7) ? 2 : 1);
        it.value = m[32:1];
        it.flag = m[0];
        it.tag = tag;
        // R9: a younger result that lands on an older one is discarded
        if (q.size() > 0 && q[$].due == it.due) return;
        q.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (!(rv === 1'b1 && res === it.value && inv === it.flag)) begin
                    failures++;
                    $display("FAIL %s cyc=%0d valid=%b result=%h inv=%b expected valid=1 result=%h inv=%b",
                             it.tag, cyc, rv, res, inv, it.value, it.flag);
                end
            end else if (rv !== 1'b0) begin
                checks++;
                failures++;
                $display("FAIL R8 cyc=%0d valid=%b result=%h expected valid=0", cyc, rv, res);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired cyc=%0d expected completion", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rv !== 1'b0 || res !== 32'h0 || inv !== 1'b0) begin
            failures++;
            $display("FAIL R10 valid=%b result=%h inv=%b expected 0 0 0", rv, res, inv);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rv !== 1'b0 || res !== 32'h0 || inv !== 1'b0) begin
            failures++;
            $display("FAIL R10 after release valid=%b result=%h inv=%b expected 0 0 0", rv, res, inv);
        end
        running = 1;

        // R1 comparisons back to back
        issue_op(3'd0, P1, P2, "R1");
        issue_op(3'd1, P2, P1, "R1");
        issue_op(3'd2, P1, P1, "R1");
        issue_op(3'd0, N1, P1, "R1");
        issue_op(3'd1, P1, P1, "R1");
        idle(2);
        // R2 flushing
        issue_op(3'd2, PZ, NZ, "R2");
        issue_op(3'd2, PSUB, PSUB2, "R2");
        issue_op(3'd0, PSUB, PSUB2, "R2");
        issue_op(3'd0, NSUB, PSUB, "R2");
        issue_op(3'd1, PSUB, NZ, "R2");
        idle(2);
        // R3 NaN comparisons
        issue_op(3'd0, QNAN, P1, "R3");
        issue_op(3'd1, P1, SNAN, "R3");
        issue_op(3'd2, QNAN, QNAN, "R3");
        issue_op(3'd2, SNAN, P1, "R3");
        idle(2);
        // R4 min/max, spaced and pipelined
        issue_op(3'd3, P1, P2, "R4");
        issue_op(3'd4, P1, P2, "R4");
        issue_op(3'd3, PSUB, PSUB2, "R4");
        issue_op(3'd4, NSUB, PSUB, "R4");
        issue_op(3'd3, NZ, PZ, "R4");
        issue_op(3'd4, NZ, PZ, "R4");
        issue_op(3'd3, NINF, N1, "R4");
        idle(3);
        // R5 NaN handling
        issue_op(3'd3, QNAN, P1, "R5");
        issue_op(3'd4, P2, SNAN, "R5");
        issue_op(3'd3, QNAN, QNAN2, "R5");
        issue_op(3'd4, SNAN, QNAN, "R5");
        idle(3);
        // R6 sign operations
        issue_op(3'd5, P1, P2, "R6");
        issue_op(3'd5, NSUB, PZ, "R6");
        issue_op(3'd6, NINF, PZ, "R6");
        issue_op(3'd6, PSUB, PZ, "R6");
        issue_op(3'd5, QNAN, SNAN, "R6");
        idle(2);
        // R7 classification of all ten classes
        issue_op(3'd7, NINF, PZ, "R7");
        issue_op(3'd7, N1, PZ, "R7");
        issue_op(3'd7, NSUB, PZ, "R7");
        issue_op(3'd7, NZ, PZ, "R7");
        issue_op(3'd7, PZ, PZ, "R7");
        issue_op(3'd7, PSUB, PZ, "R7");
        issue_op(3'd7, P2, PZ, "R7");
        issue_op(3'd7, PINF, PZ, "R7");
        issue_op(3'd7, SNAN, PZ, "R7");
        issue_op(3'd7, QNAN2, PZ, "R7");
        idle(3);
        // R8 one-cycle op followed by two-cycle op: both delivered in turn
        issue_op(3'd6, N1, PZ, "R8");
        issue_op(3'd7, N1, PZ, "R8");
        idle(3);
        // R9 collision: min then negate in the next cycle
        issue_op(3'd3, P2, N1, "R9");
        issue_op(3'd5, P1, PZ, "R9");
        idle(2);
        issue_op(3'd7, PINF, PZ, "R9");
        issue_op(3'd0, P1, P2, "R9");
        idle(4);

        if (q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R8 %0d results missing expected 0", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule